// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a clocked host and an asynchronous 32K-word by 16-bit static RAM that has one active-low enable per byte lane. The host presents one request at a time through a valid/ready handshake: a write flag, a word address, write data and a two-bit lane mask. The controller turns it into a timed sequence on the memory pins. Every memory-side interval is set in nanoseconds through parameters and converted to whole clock cycles at elaboration.

Writes follow a fixed order. The controller asserts chip and lane enables, then pulses write enable. It drives the data bus only while write enable is low and during the hold phase after it. Output enable stays high for the whole write, so the memory never drives the bus at the same time. After each write there is a turnaround gap with every pin released. Reads hold chip, output and lane enables low until the slowest access time has passed plus one margin cycle. The read data returns with a one-cycle strobe, and lanes outside the mask read back as zero. A request with an empty mask touches no pin.

Top module: `sram_async_ctl`

## Requirements
- R1: While and after reset, req_ready is 1, sram_ce_n, sram_oe_n and sram_we_n are 1, sram_be_n is 2'b11, sram_dq_oe is 0 and rsp_valid is 0.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from that edge until the memory cycle, including any turnaround, has ended.
- R3: A read with a nonzero mask holds sram_ce_n=0, sram_oe_n=0, sram_we_n=1, sram_be_n=~mask and a stable address for READ_CYC cycles, where READ_CYC is the slowest of the address, output-enable and lane-enable access times in cycles plus one (2 at defaults). rsp_valid is high for exactly one cycle, READ_CYC edges after the accepting edge.
- R4: Mask bit 0 selects the lower lane (data bits 7:0, sram_be_n[0]) and mask bit 1 selects the upper lane (bits 15:8, sram_be_n[1]). rsp_rdata carries sram_dq_in for the selected lanes, sampled in the last access cycle, and zero for the other lanes.
- R5: A write with a nonzero mask shows a setup phase (1 cycle at defaults) with chip and lane enables low and sram_we_n=1. Next comes a write pulse with sram_we_n=0 (1 cycle), then a hold phase with sram_we_n=1 and chip enable still low (1 cycle). sram_oe_n is 1 throughout.
- R6: sram_dq_oe is 1 exactly during the write pulse and hold phases, and sram_dq_out equals the request's write data there.
- R7: sram_dq_oe is never 1 while sram_oe_n is 0.
- R8: After every write, a turnaround phase of at least one cycle follows, with all enables high, sram_dq_oe 0 and req_ready 0. Only then can another request be taken.
- R9: A request with mask 2'b00 leaves chip, output and write enables high. As a read it returns rsp_rdata=0 with rsp_valid one edge after acceptance. As a write it changes no memory word.
- R10: A write never raises rsp_valid.
- R11: The address and lane enables stay stable for as long as chip enable is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | Read data strobe, one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 15 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_be_n | output | 2 | Lane enables, active low, bit 0 lower |
| sram_dq_out | output | 16 | Data driven to memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | 16 | Data read from memory |

## Verification
Every pin state and handshake result has a fixed due cycle, counted from the accepting clock edge k. For a read, the pins are active in cycles k and k+1 and the strobe comes after edge k+2. For an empty read the strobe comes after edge k+1. A write runs setup, pulse, hold and turnaround in cycles k to k+3, and ready returns at k+4. The driver samples each of those cycles at the falling edge and compares it with the phase expected there. It stores the edge number at which each read is due in the scoreboard, and the monitor checks that rsp_valid arrives in exactly that cycle, carrying the value the bench's own memory image predicts.

// File: rtl/sram_ctl_pkg.sv
// Shared types and elaboration helpers for the asynchronous SRAM controller.
// Assumes all timing values are non-negative integers in nanoseconds.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NULL,
        ST_RD,
        ST_WSET,
        ST_WPUL,
        ST_WHLD,
        ST_WTRN
    } phase_t;

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int ns_to_cyc(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
// Phase length down-counter. A load of N-1 on entry to a phase makes the
// phase last N cycles; done is high in the last cycle of the phase.
module sram_ctl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_fsm.sv
// Sequencer: accepts one host request in idle and walks it through the
// read, write or empty-mask phases. Holds the captured request fields.
// Assumes every cycle count parameter is at least 1.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 16,
    parameter int LANES     = 2,
    parameter int CNT_W     = 2,
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 1,
    parameter int HOLD_CYC  = 1,
    parameter int TURN_CYC  = 1,
    parameter int READ_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic              done,
    output phase_t            state_q,
    output phase_t            state_d,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [ADDR_W-1:0] addr_d,
    output logic [DATA_W-1:0] wdata_d,
    output logic [LANES-1:0]  mask_d,
    output logic [LANES-1:0]  mask_q,
    output logic              write_q
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              take;

    assign take = (state_q == ST_IDLE) && req_valid;

    // Capture request fields on the accepting edge.
    always_comb begin
        addr_d  = take ? req_addr  : addr_q;
        wdata_d = take ? req_wdata : wdata_q;
        mask_d  = take ? req_mask  : mask_q;
    end

    // Next phase and timer reload selection.
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                if (req_mask == '0) begin
                    state_d = ST_NULL;
                end else if (req_write) begin
                    state_d  = ST_WSET;
                    load     = 1'b1;
                    load_val = CNT_W'(SETUP_CYC - 1);
                end else begin
                    state_d  = ST_RD;
                    load     = 1'b1;
                    load_val = CNT_W'(READ_CYC - 1);
                end
            end
            ST_NULL: state_d = ST_IDLE;
            ST_RD:   if (done) state_d = ST_IDLE;
            ST_WSET: if (done) begin
                state_d  = ST_WPUL;
                load     = 1'b1;
                load_val = CNT_W'(PULSE_CYC - 1);
            end
            ST_WPUL: if (done) begin
                state_d  = ST_WHLD;
                load     = 1'b1;
                load_val = CNT_W'(HOLD_CYC - 1);
            end
            ST_WHLD: if (done) begin
                state_d  = ST_WTRN;
                load     = 1'b1;
                load_val = CNT_W'(TURN_CYC - 1);
            end
            ST_WTRN: if (done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            write_q <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            wdata_q <= wdata_d;
            mask_q  <= mask_d;
            if (take)
                write_q <= req_write;
        end
    end
endmodule

// File: rtl/sram_ctl_pins.sv
// Registered memory pin decode. Pins are computed from the next phase so
// they change only on clock edges and line up with the phase register.
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            state_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [DATA_W-1:0] wdata_d,
    input  logic [LANES-1:0]  mask_d,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [LANES-1:0]  sram_be_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe
);
    logic sel;

    assign sel = (state_d == ST_RD) || (state_d == ST_WSET) ||
                 (state_d == ST_WPUL) || (state_d == ST_WHLD);

    // Drive the pins from the decoded next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr   <= '0;
            sram_ce_n   <= 1'b1;
            sram_oe_n   <= 1'b1;
            sram_we_n   <= 1'b1;
            sram_be_n   <= '1;
            sram_dq_out <= '0;
            sram_dq_oe  <= 1'b0;
        end else begin
            sram_addr   <= addr_d;
            sram_ce_n   <= !sel;
            sram_oe_n   <= !(state_d == ST_RD);
            sram_we_n   <= !(state_d == ST_WPUL);
            sram_be_n   <= sel ? ~mask_d : '1;
            sram_dq_out <= wdata_d;
            sram_dq_oe  <= (state_d == ST_WPUL) || (state_d == ST_WHLD);
        end
    end
endmodule

// File: rtl/sram_ctl_rdcap.sv
// Read data capture: samples the memory bus in the last access cycle,
// zeroes unselected lanes, and pulses the response strobe.
module sram_ctl_rdcap
    import sram_ctl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            state_q,
    input  logic              done,
    input  logic [LANES-1:0]  mask_q,
    input  logic              write_q,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] lane_keep;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_keep[i*LANE_W +: LANE_W] = {LANE_W{mask_q[i]}};
    end

    // Strobe and data register for read completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            if (state_q == ST_RD && done) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= sram_dq_in & lane_keep;
            end else if (state_q == ST_NULL && !write_q) begin
                rsp_valid <= 1'b1;
                rsp_rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/sram_async_ctl.sv
// Top level of the asynchronous SRAM controller. Converts nanosecond timing
// parameters into cycle counts and wires sequencer, timer, pin decode and
// read capture. Assumes one outstanding request and a bus that never floats
// into the capture path (the pad logic resolves the tri-state).
module sram_async_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 16,
    parameter int LANES     = 2,
    parameter int CLK_NS    = 10,
    parameter int T_AS_NS   = 0,
    parameter int T_PWE_NS  = 7,
    parameter int T_SD_NS   = 5,
    parameter int T_SCE_NS  = 8,
    parameter int T_AW_NS   = 7,
    parameter int T_BW_NS   = 7,
    parameter int T_HD_NS   = 0,
    parameter int T_AH_NS   = 0,
    parameter int T_WC_NS   = 10,
    parameter int T_AA_NS   = 10,
    parameter int T_DOE_NS  = 5,
    parameter int T_DBE_NS  = 5,
    parameter int T_RC_NS   = 10,
    parameter int T_HZ_NS   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [LANES-1:0]  sram_be_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int SETUP_CYC = imax(1, ns_to_cyc(T_AS_NS, CLK_NS));
    localparam int PW_A      = imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS));
    localparam int PW_B      = imax(ns_to_cyc(T_SCE_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS));
    localparam int PW_C      = imax(PW_B, ns_to_cyc(T_BW_NS, CLK_NS)) - SETUP_CYC;
    localparam int PULSE_CYC = imax(1, imax(PW_A, PW_C));
    localparam int HOLD_MIN  = imax(1, ns_to_cyc(imax(T_HD_NS, T_AH_NS), CLK_NS));
    localparam int HOLD_CYC  = imax(HOLD_MIN, ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_CYC - PULSE_CYC);
    localparam int TURN_CYC  = imax(1, ns_to_cyc(T_HZ_NS, CLK_NS));
    localparam int ACC_NS    = imax(T_AA_NS, imax(T_DOE_NS, T_DBE_NS));
    localparam int READ_CYC  = imax(ns_to_cyc(ACC_NS, CLK_NS) + 1, ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int MAX_CYC   = imax(imax(SETUP_CYC, PULSE_CYC),
                                    imax(imax(HOLD_CYC, TURN_CYC), READ_CYC));
    localparam int CNT_W     = imax(1, $clog2(MAX_CYC));

    phase_t            state_q;
    phase_t            state_d;
    logic              load;
    logic [CNT_W-1:0]  load_val;
    logic              done;
    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] wdata_d;
    logic [LANES-1:0]  mask_d;
    logic [LANES-1:0]  mask_q;
    logic              write_q;

    assign req_ready = (state_q == ST_IDLE);

    sram_ctl_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES), .CNT_W(CNT_W),
        .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC),
        .TURN_CYC(TURN_CYC), .READ_CYC(READ_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .done(done),
        .state_q(state_q), .state_d(state_d), .load(load), .load_val(load_val),
        .addr_d(addr_d), .wdata_d(wdata_d), .mask_d(mask_d), .mask_q(mask_q),
        .write_q(write_q)
    );

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
    );

    sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
        .clk(clk), .rst_n(rst_n), .state_d(state_d), .addr_d(addr_d),
        .wdata_d(wdata_d), .mask_d(mask_d), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe)
    );

    sram_ctl_rdcap #(.DATA_W(DATA_W), .LANES(LANES)) u_rdcap (
        .clk(clk), .rst_n(rst_n), .state_q(state_q), .done(done),
        .mask_q(mask_q), .write_q(write_q), .sram_dq_in(sram_dq_in),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: rtl/sram_async_ctl_chk.sv
// Protocol checker for the SRAM controller pins and host handshake.
// Attached to every instance of the top module through bind.
module sram_async_ctl_chk #(
    parameter int ADDR_W = 15,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [LANES-1:0]  sram_be_n,
    input logic              sram_dq_oe
);
    // R1: one edge into reset everything is released
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_valid));

    // R2: no host acceptance while the memory is selected
    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> !req_ready);

    // R3: the read strobe is a single-cycle pulse
    p_strobe_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5: write enable only with chip and a lane selected, outputs off
    p_we_context_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n && (sram_be_n != '1)));

    // R6: data hold after the write-ending edge
    p_hold_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!sram_we_n) && sram_we_n) |-> (sram_dq_oe && !sram_ce_n));

    // R7: controller and memory never drive together
    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    // R8: releasing the bus is followed by a fully idle cycle
    p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sram_dq_oe) && !sram_dq_oe) |-> (sram_ce_n && sram_we_n && !req_ready));

    // R11: address and lanes frozen while selected
    p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_be_n)));
endmodule

bind sram_async_ctl sram_async_ctl_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/tb_sram_async_ctl.sv
// Scoreboard bench: a driver task issues requests and checks pin phases,
// read expectations go into a queue, a monitor pops and compares them.
module tb_sram_async_ctl;
    localparam int CLK_PERIOD = 10;
    // Expected cycle counts at default timing with a 10 ns clock
    localparam int EXP_READ = 2;   // 10 ns access -> 1 cycle, plus margin

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [14:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_out;
    logic [15:0] sram_dq_in;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [15:0] mem [32];
    logic [15:0] exp_mem [32];
    logic [15:0] q_data [$];
    int          q_due [$];

    sram_async_ctl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] seed(input int i);
        return 16'h4B00 ^ 16'(i * 16'h0123);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h cyc=%0d", tag, act, exp, cyc);
        end
    endtask

    // Memory model: drives selected lanes on read, junk 8'hA5 elsewhere.
    always_comb begin
        for (int i = 0; i < 2; i++) begin
            if (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_be_n[i])
                sram_dq_in[i*8 +: 8] = mem[sram_addr[4:0]][i*8 +: 8];
            else
                sram_dq_in[i*8 +: 8] = 8'hA5;
        end
    end

    // Memory model: stores lanes on the write-ending edge of write enable.
    always @(posedge sram_we_n) begin
        if (rst_n && !sram_ce_n) begin
            chk(sram_dq_oe, "R6 data driven at write end", {31'd0, sram_dq_oe}, 32'd1);
            for (int i = 0; i < 2; i++)
                if (!sram_be_n[i])
                    mem[sram_addr[4:0]][i*8 +: 8] = sram_dq_out[i*8 +: 8];
        end
    end

    // Monitor: compare every response against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(!(sram_dq_oe && !sram_oe_n), "R7 contention", {31'd0, sram_dq_oe}, 32'd0);
            if (rsp_valid) begin
                if (q_data.size() == 0) begin
                    chk(1'b0, "R10 unexpected rsp_valid", 32'd1, 32'd0);
                end else begin
                    automatic logic [15:0] ed = q_data.pop_front();
                    automatic int          du = q_due.pop_front();
                    chk(rsp_rdata == ed, "R4 read data", {16'd0, rsp_rdata}, {16'd0, ed});
                    chk(cyc == du, "R3 strobe cycle", cyc, du);
                end
            end
        end
    end

    // Driver: issue one request and check each pin phase at its due cycle.
    task automatic do_req(input bit wr, input logic [14:0] a, input logic [15:0] d, input logic [1:0] m);
        int acc;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk); #1; acc = cyc;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = 16'h0000; req_addr = 15'h7FFF;
        if (m == 2'b00) begin
            // R9: no pin activity, read strobe one edge later
            chk(sram_ce_n && sram_we_n && sram_oe_n, "R9 empty mask pins", {29'd0, sram_ce_n, sram_we_n, sram_oe_n}, 32'd7);
            chk(!req_ready, "R2 busy on empty", {31'd0, req_ready}, 32'd0);
            if (!wr) begin q_data.push_back(16'h0000); q_due.push_back(acc + 1); end
            @(negedge clk);
        end else if (wr) begin
            for (int i = 0; i < 2; i++)
                if (m[i]) exp_mem[a[4:0]][i*8 +: 8] = d[i*8 +: 8];
            // setup
            chk(!sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == ~m && !sram_dq_oe,
                "R5 setup phase", {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_be_n}, {27'd0, 1'b0, 1'b1, 1'b1, ~m});
            chk(!req_ready, "R2 busy in write", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            chk(!sram_we_n && !sram_ce_n && sram_oe_n, "R5 pulse phase", {29'd0, sram_ce_n, sram_we_n, sram_oe_n}, 32'd1);
            chk(sram_dq_oe && sram_dq_out == d && sram_addr == a, "R6 drive in pulse", {16'd0, sram_dq_out}, {16'd0, d});
            @(negedge clk);
            chk(sram_we_n && !sram_ce_n && sram_dq_oe && sram_addr == a, "R5 R6 hold phase", {30'd0, sram_ce_n, sram_dq_oe}, 32'd1);
            @(negedge clk);
            chk(sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11 && !sram_dq_oe && !req_ready,
                "R8 turnaround", {28'd0, sram_ce_n, sram_dq_oe, req_ready, sram_we_n}, 32'h9);
            @(negedge clk);
            chk(req_ready, "R2 ready after write", {31'd0, req_ready}, 32'd1);
        end else begin
            begin
                automatic logic [15:0] e;
                for (int i = 0; i < 2; i++)
                    e[i*8 +: 8] = m[i] ? exp_mem[a[4:0]][i*8 +: 8] : 8'h00;
                q_data.push_back(e); q_due.push_back(acc + EXP_READ);
            end
            for (int k = 0; k < EXP_READ; k++) begin
                chk(!sram_ce_n && !sram_oe_n && sram_we_n && sram_be_n == ~m && sram_addr == a,
                    "R3 read pins", {27'd0, sram_ce_n, sram_oe_n, sram_we_n, sram_be_n}, {27'd0, 1'b0, 1'b0, 1'b1, ~m});
                chk(!req_ready, "R2 busy in read", {31'd0, req_ready}, 32'd0);
                @(negedge clk);
            end
            chk(sram_ce_n && req_ready, "R3 R2 read end", {30'd0, sram_ce_n, req_ready}, 32'd3);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin mem[i] = seed(i); exp_mem[i] = seed(i); end
        repeat (3) @(negedge clk);
        chk(req_ready && sram_ce_n && sram_oe_n && sram_we_n && sram_be_n == 2'b11 && !sram_dq_oe && !rsp_valid,
            "R1 reset state", {26'd0, req_ready, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rsp_valid}, 32'h3C);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && sram_ce_n && !rsp_valid, "R1 after reset", {30'd0, req_ready, rsp_valid}, 32'd2);

        do_req(1'b1, 15'd3, 16'hBEEF, 2'b11);   // full write
        do_req(1'b0, 15'd3, 16'h0000, 2'b11);   // write then read: turnaround
        do_req(1'b1, 15'd3, 16'h1122, 2'b01);   // lower lane only
        do_req(1'b0, 15'd3, 16'h0000, 2'b10);   // upper only, lower reads zero
        do_req(1'b0, 15'd3, 16'h0000, 2'b11);
        do_req(1'b1, 15'd5, 16'h3344, 2'b10);   // upper lane only
        do_req(1'b0, 15'd5, 16'h0000, 2'b01);
        do_req(1'b0, 15'd5, 16'h0000, 2'b11);
        do_req(1'b0, 15'd5, 16'h0000, 2'b00);   // R9 empty read
        do_req(1'b1, 15'd7, 16'hFFFF, 2'b00);   // R9 empty write, no strobe (R10)
        do_req(1'b0, 15'd7, 16'h0000, 2'b11);
        for (int i = 0; i < 4; i++) do_req(1'b0, 15'(i), 16'h0000, 2'b11);
        for (int i = 8; i < 12; i++) do_req(1'b1, 15'(i), 16'(i * 16'h1111), 2'b11);
        for (int i = 8; i < 12; i++) do_req(1'b0, 15'(i), 16'h0000, 2'(i - 7));

        repeat (4) @(negedge clk);
        chk(q_data.size() == 0, "R3 all reads answered", q_data.size(), 32'd0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL R2 watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule